// File: doc/BRIEF.md
# SDRAM Bank State and Timing Tracker

This block follows every bank of an SDRAM device on behalf of a memory controller. It watches the decoded command stream and the clock-enable level. From these it keeps each bank in one of four phases: idle, opening (waiting out the activate-to-column delay), open with a latched row, or closing (waiting out the precharge time). It also times the all-bank refresh and notices when the device slips into power-down. The scheduler reads the per-bank flags to decide what it may issue next. The data path and the choice of command are outside this block.

Timing limits are specified in nanoseconds. The integrator converts them to whole clock cycles by rounding up against the clock period; the package carries a helper for that. The three cycle counts arrive on configuration inputs and are captured while reset is held. Any command that breaks the rules is dropped without touching bank state and sets a sticky error flag. The bank count is a parameter and defaults to four.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While `rst` is high on a clock edge, every bank returns to idle with an open-row value of 0, and `proto_err`, `power_down` and `refresh_busy` clear. The three timing inputs are captured on that edge, and changes to them after reset have no effect.
- R2: An activate (`cmd_op` = 1) to an idle bank, outside refresh, opens that bank. Its `bank_idle` bit falls after that edge, and its `open_row` slice takes `cmd_row`.
- R3: After an activate accepted on edge k, the bank's `bank_ready` bit rises after edge k+tRCD-1. A read (`cmd_op` = 2) or write (`cmd_op` = 3) is therefore legal from edge k+tRCD on.
- R4: A precharge (`cmd_op` = 4) to an open bank, or a precharge-all (`cmd_op` = 5) to every open bank, drops `bank_ready` at once. The bank's `bank_idle` bit rises again after edge k+tRP-1. A precharge that finds a bank not open changes nothing and is not an error.
- R5: A refresh (`cmd_op` = 6) is accepted only when all banks are idle. `refresh_busy` is then high for tRFC-1 cycles, and all `bank_idle` bits and `all_idle` stay low over that span.
- R6: An activate to a bank that is not idle (or during refresh), a read or write to a bank that is not ready, and a refresh while any bank is not idle are illegal. Each one leaves every bank state and open row unchanged.
- R7: `proto_err` is set by any illegal command and stays high until reset.
- R8: `power_down` is set on an edge where `cke` is low, all banks are idle and `cmd_op` is 0 (no operation). It clears on the first edge with `cke` high. Lowering `cke` while a bank is busy does not set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; timing inputs sampled while high |
| cfg_trcd | input | CNT_W | Activate-to-column delay in cycles |
| cfg_trp | input | CNT_W | Precharge time in cycles |
| cfg_trfc | input | CNT_W | Refresh cycle time in cycles |
| cke | input | 1 | Clock-enable level seen by the device |
| cmd_op | input | 3 | Command code: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 refresh, 7 treated as nop |
| cmd_bank | input | BANK_W | Target bank |
| cmd_row | input | ROW_W | Row for activate |
| bank_ready | output | NUM_BANKS | Bank open and past tRCD |
| bank_idle | output | NUM_BANKS | Bank idle and no refresh running |
| open_row | output | NUM_BANKS*ROW_W | Latched row per bank, bank 0 in the low slice |
| all_idle | output | 1 | Every bank idle |
| refresh_busy | output | 1 | Refresh cycle time running |
| power_down | output | 1 | Device in power-down |
| proto_err | output | 1 | Sticky illegal-command flag |

## Verification
The legal sequence runs two banks through overlapping activate, read and precharge windows, then a precharge-all and a refresh. This shows whether each bank's timer is separate and whether the flags move on the exact edge that tRCD, tRP and tRFC require. Clock-enable is then dropped once with every bank idle and once with a bank opening, which separates a proper power-down entry from a false one. Three illegal cases each start from a fresh reset: a second activate, a write with no activate, and a refresh with a bank open. These show that a rejected command leaves the state and open row untouched, that the error flag is sticky, and that reset clears it.

// File: rtl/sdram_bank_pkg.sv
package sdram_bank_pkg;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPENING = 2'd1,
        BK_OPEN    = 2'd2,
        BK_CLOSING = 2'd3
    } bank_state_e;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_PREA = 3'd5,
        OP_REF  = 3'd6,
        OP_RSVD = 3'd7
    } cmd_op_e;

    // Per-bank grant produced by the legality decoder
    typedef struct packed {
        logic act;
        logic pre;
        logic rw;
    } bank_go_t;

    // Round a nanosecond limit up to whole cycles of a clock given in ps
    function automatic int unsigned span_cycles(input int unsigned ns,
                                                input int unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic [2:0]                        op,
    input  logic [BANK_W-1:0]                 bank,
    input  bank_state_e [NUM_BANKS-1:0]       st,
    input  logic                              ref_busy,
    output bank_go_t [NUM_BANKS-1:0]          go,
    output logic                              ref_go,
    output logic                              illegal
);
    logic all_st_idle;

    always_comb begin
        all_st_idle = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (st[b] != BK_IDLE) all_st_idle = 1'b0;
        end
    end

    always_comb begin
        go      = '0;
        ref_go  = 1'b0;
        illegal = 1'b0;
        case (cmd_op_e'(op))
            OP_ACT: begin
                if (st[bank] == BK_IDLE && !ref_busy) go[bank].act = 1'b1;
                else                                  illegal       = 1'b1;
            end
            OP_RD, OP_WR: begin
                if (st[bank] == BK_OPEN) go[bank].rw = 1'b1;
                else                     illegal     = 1'b1;
            end
            OP_PRE: begin
                if (st[bank] == BK_OPEN) go[bank].pre = 1'b1;
            end
            OP_PREA: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (st[b] == BK_OPEN) go[b].pre = 1'b1;
                end
            end
            OP_REF: begin
                if (all_st_idle && !ref_busy) ref_go  = 1'b1;
                else                          illegal = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_bank_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  t_rcd,
    input  logic [CNT_W-1:0]  t_rp,
    input  bank_go_t          go,
    input  logic [ROW_W-1:0]  row_in,
    output bank_state_e       state,
    output logic [ROW_W-1:0]  row_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BK_IDLE;
            cnt   <= '0;
            row_q <= '0;
        end else begin
            case (state)
                BK_IDLE: if (go.act) begin
                    row_q <= row_in;
                    cnt   <= t_rcd - ONE;
                    state <= (t_rcd > ONE) ? BK_OPENING : BK_OPEN;
                end
                BK_OPENING: begin
                    cnt <= cnt - ONE;
                    if (cnt == ONE) state <= BK_OPEN;
                end
                BK_OPEN: if (go.pre) begin
                    cnt   <= t_rp - ONE;
                    state <= (t_rp > ONE) ? BK_CLOSING : BK_IDLE;
                end
                BK_CLOSING: begin
                    cnt <= cnt - ONE;
                    if (cnt == ONE) state <= BK_IDLE;
                end
                default: state <= BK_IDLE;
            endcase
        end
    end

    assert_act_idle_R2: assert property (@(posedge clk) disable iff (rst)
        go.act |-> state == BK_IDLE);
    assert_rw_open_R3: assert property (@(posedge clk) disable iff (rst)
        go.rw |-> state == BK_OPEN);
    assert_pre_open_R4: assert property (@(posedge clk) disable iff (rst)
        go.pre |=> state != BK_OPEN);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  t_rfc,
    input  logic              ref_go,
    input  logic              banks_quiet,
    output logic              busy
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt - ONE;
            if (cnt == ONE) busy <= 1'b0;
        end else if (ref_go) begin
            cnt  <= t_rfc - ONE;
            busy <= t_rfc > ONE;
        end
    end

    assert_ref_idle_R5: assert property (@(posedge clk) disable iff (rst)
        ref_go |-> banks_quiet && !busy);

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int CNT_W     = 8,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CNT_W-1:0]              cfg_trcd,
    input  logic [CNT_W-1:0]              cfg_trp,
    input  logic [CNT_W-1:0]              cfg_trfc,
    input  logic                          cke,
    input  logic [2:0]                    cmd_op,
    input  logic [BANK_W-1:0]             cmd_bank,
    input  logic [ROW_W-1:0]              cmd_row,
    output logic [NUM_BANKS-1:0]          bank_ready,
    output logic [NUM_BANKS-1:0]          bank_idle,
    output logic [NUM_BANKS*ROW_W-1:0]    open_row,
    output logic                          all_idle,
    output logic                          refresh_busy,
    output logic                          power_down,
    output logic                          proto_err
);
    logic [CNT_W-1:0] t_rcd, t_rp, t_rfc;
    bank_state_e [NUM_BANKS-1:0] st;
    bank_go_t    [NUM_BANKS-1:0] go;
    logic ref_go, illegal, banks_quiet;

    always_ff @(posedge clk) begin
        if (rst) begin
            t_rcd <= cfg_trcd;
            t_rp  <= cfg_trp;
            t_rfc <= cfg_trfc;
        end
    end

    sdram_cmd_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_decode (
        .op(cmd_op), .bank(cmd_bank), .st(st), .ref_busy(refresh_busy),
        .go(go), .ref_go(ref_go), .illegal(illegal)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdram_bank_fsm #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_fsm (
            .clk(clk), .rst(rst), .t_rcd(t_rcd), .t_rp(t_rp),
            .go(go[g]), .row_in(cmd_row),
            .state(st[g]), .row_q(open_row[g*ROW_W +: ROW_W])
        );
        assign bank_ready[g] = (st[g] == BK_OPEN);
        assign bank_idle[g]  = (st[g] == BK_IDLE) && !refresh_busy;
    end

    always_comb begin
        banks_quiet = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (st[b] != BK_IDLE) banks_quiet = 1'b0;
        end
    end

    sdram_refresh_timer #(.CNT_W(CNT_W)) u_refresh (
        .clk(clk), .rst(rst), .t_rfc(t_rfc), .ref_go(ref_go),
        .banks_quiet(banks_quiet), .busy(refresh_busy)
    );

    assign all_idle = &bank_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            proto_err  <= 1'b0;
            power_down <= 1'b0;
        end else begin
            if (illegal) proto_err <= 1'b1;
            if (cke)
                power_down <= 1'b0;
            else if (all_idle && cmd_op == 3'd0)
                power_down <= 1'b1;
        end
    end

    assert_illegal_keeps_rows_R6: assert property (@(posedge clk) disable iff (rst)
        illegal |=> $stable(open_row));
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);
    assert_pd_exit_R8: assert property (@(posedge clk) disable iff (rst)
        cke |=> !power_down);
    assert_pd_needs_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(power_down) |-> !$past(cke));

endmodule

// File: tb/tb_sdram_bank_tracker.sv
`timescale 1ns/1ps
module tb_sdram_bank_tracker;
    import sdram_bank_pkg::*;

    localparam int NB = 4;
    localparam int RW = 13;
    localparam int CW = 8;
    localparam int PERIOD_PS = 5000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CW-1:0] cfg_trcd, cfg_trp, cfg_trfc;
    logic cke = 1'b1;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = '0;
    logic [RW-1:0] cmd_row = '0;
    logic [NB-1:0] bank_ready, bank_idle;
    logic [NB*RW-1:0] open_row;
    logic all_idle, refresh_busy, power_down, proto_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string req;
        logic [NB-1:0] rdy;
        logic [NB-1:0] idl;
        logic ai;
        logic rb;
        logic pd;
        logic err;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    sdram_bank_tracker dut (
        .clk(clk), .rst(rst), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
        .cfg_trfc(cfg_trfc), .cke(cke), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .bank_ready(bank_ready), .bank_idle(bank_idle),
        .open_row(open_row), .all_idle(all_idle), .refresh_busy(refresh_busy),
        .power_down(power_down), .proto_err(proto_err)
    );

    // Monitor: compare one expected item per clock, half a period after the edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (bank_ready !== e.rdy || bank_idle !== e.idl || all_idle !== e.ai ||
                refresh_busy !== e.rb || power_down !== e.pd || proto_err !== e.err) begin
                errors++;
                $display("FAIL %s rdy=%b/%b idle=%b/%b all=%b/%b rb=%b/%b pd=%b/%b err=%b/%b",
                         e.req, bank_ready, e.rdy, bank_idle, e.idl, all_idle, e.ai,
                         refresh_busy, e.rb, power_down, e.pd, proto_err, e.err);
            end
        end
    end

    // Driver: apply one command for one edge, queue what must follow it
    task automatic cyc(input logic [2:0] op, input int bank, input int row, input logic ck,
                       input string req, input logic [NB-1:0] rdy, input logic [NB-1:0] idl,
                       input logic rb, input logic pd, input logic err);
        exp_t e;
        cmd_op   = op;
        cmd_bank = 2'(bank);
        cmd_row  = RW'(row);
        cke      = ck;
        @(posedge clk);
        e.req = req; e.rdy = rdy; e.idl = idl; e.ai = &idl;
        e.rb = rb; e.pd = pd; e.err = err;
        sb.push_back(e);
        #1;
    endtask

    task automatic check_row(input int bank, input int val, input string req);
        logic [RW-1:0] got;
        got = open_row[bank*RW +: RW];
        checks++;
        if (got !== RW'(val)) begin
            errors++;
            $display("FAIL %s open_row[%0d]=%h expected %h", req, bank, got, RW'(val));
        end
    endtask

    task automatic do_reset();
        cfg_trcd = CW'(span_cycles(15, PERIOD_PS));
        cfg_trp  = CW'(span_cycles(10, PERIOD_PS));
        cfg_trfc = CW'(span_cycles(20, PERIOD_PS));
        rst = 1'b1; cmd_op = 3'd0; cke = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // later changes must be ignored (R1)
        cfg_trcd = 8'd9; cfg_trp = 8'd9; cfg_trfc = 8'd9;
    endtask

    initial begin
        do_reset();
        // tRCD=3, tRP=2, tRFC=4 cycles at 5 ns
        cyc(0, 0, 0, 1, "R1 reset state", 4'b0000, 4'b1111, 0, 0, 0);
        check_row(0, 0, "R1 row cleared");
        cyc(4, 3, 0, 1, "R4 precharge idle bank no effect", 4'b0000, 4'b1111, 0, 0, 0);
        cyc(1, 0, 'h55, 1, "R2 activate bank0", 4'b0000, 4'b1110, 0, 0, 0);
        cyc(0, 0, 0, 1, "R3 not ready yet", 4'b0000, 4'b1110, 0, 0, 0);
        cyc(0, 0, 0, 1, "R3 ready after tRCD-1", 4'b0001, 4'b1110, 0, 0, 0);
        check_row(0, 'h55, "R2 open row bank0");
        cyc(2, 0, 0, 1, "R3 read at tRCD", 4'b0001, 4'b1110, 0, 0, 0);
        cyc(1, 1, 'h1AA, 1, "R2 activate bank1", 4'b0001, 4'b1100, 0, 0, 0);
        cyc(0, 0, 0, 1, "R3 bank1 opening", 4'b0001, 4'b1100, 0, 0, 0);
        cyc(4, 0, 0, 1, "R4 precharge bank0", 4'b0010, 4'b1100, 0, 0, 0);
        cyc(0, 0, 0, 1, "R4 bank0 idle after tRP-1", 4'b0010, 4'b1101, 0, 0, 0);
        check_row(1, 'h1AA, "R2 open row bank1");
        cyc(5, 0, 0, 1, "R4 precharge-all", 4'b0000, 4'b1101, 0, 0, 0);
        cyc(0, 0, 0, 1, "R4 all idle", 4'b0000, 4'b1111, 0, 0, 0);
        cyc(6, 0, 0, 1, "R5 refresh start", 4'b0000, 4'b0000, 1, 0, 0);
        cyc(0, 0, 0, 1, "R5 refresh busy", 4'b0000, 4'b0000, 1, 0, 0);
        cyc(0, 0, 0, 1, "R5 refresh busy", 4'b0000, 4'b0000, 1, 0, 0);
        cyc(0, 0, 0, 1, "R5 refresh done", 4'b0000, 4'b1111, 0, 0, 0);
        cyc(0, 0, 0, 0, "R8 enter power-down", 4'b0000, 4'b1111, 0, 1, 0);
        cyc(0, 0, 0, 0, "R8 hold power-down", 4'b0000, 4'b1111, 0, 1, 0);
        cyc(0, 0, 0, 1, "R8 exit power-down", 4'b0000, 4'b1111, 0, 0, 0);
        cyc(1, 2, 7, 1, "R2 activate bank2", 4'b0000, 4'b1011, 0, 0, 0);
        cyc(0, 0, 0, 0, "R8 no power-down while busy", 4'b0000, 4'b1011, 0, 0, 0);
        cyc(0, 0, 0, 1, "R3 bank2 ready", 4'b0100, 4'b1011, 0, 0, 0);

        do_reset();
        cyc(1, 3, 9, 1, "R2 activate bank3", 4'b0000, 4'b0111, 0, 0, 0);
        cyc(1, 3, 'h33, 1, "R6 activate non-idle bank", 4'b0000, 4'b0111, 0, 0, 1);
        check_row(3, 9, "R6 row kept on illegal activate");
        cyc(0, 0, 0, 1, "R7 error sticky", 4'b1000, 4'b0111, 0, 0, 1);

        do_reset();
        cyc(0, 0, 0, 1, "R1 reset clears error", 4'b0000, 4'b1111, 0, 0, 0);
        cyc(3, 0, 0, 1, "R6 write to closed bank", 4'b0000, 4'b1111, 0, 0, 1);
        cyc(0, 0, 0, 1, "R7 error sticky", 4'b0000, 4'b1111, 0, 0, 1);

        do_reset();
        cyc(1, 1, 3, 1, "R2 activate bank1", 4'b0000, 4'b1101, 0, 0, 0);
        cyc(6, 0, 0, 1, "R6 refresh with open bank", 4'b0000, 4'b1101, 0, 0, 1);
        cyc(0, 0, 0, 1, "R7 error sticky bank1 ready", 4'b0010, 4'b1101, 0, 0, 1);

        @(negedge clk);
        #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule